// File: doc/BRIEF.md
# Monochrome to 4-bit grayscale tile converter

The block turns one 8x8 one-bit-per-pixel tile into the nibble-packed layout a 16-level grayscale display controller expects. Source bytes arrive one per handshake on a valid/ready stream. Each source byte is one pixel column, with its least significant bit holding the top row. Once the whole tile is held internally, the block sends out one byte per handshake. Each output byte carries two horizontally adjacent pixels, one per nibble. A lit source pixel becomes full intensity (0xF) and a dark one becomes 0x0.

A mode input selects the width of the output. In full width the block emits four bytes per row, 32 bytes in total. In narrow width it emits three bytes per row, 24 bytes in total, for a final tile that only partly covers the panel. In narrow width the last two source bytes are still accepted but their pixels are dropped. The block works on one tile at a time. It takes no new input until the previous tile has fully drained.

Top module: `gray_tile_xpose`

## Requirements
- R1: After synchronous active-low reset, `s_ready` is 1 and `m_valid` is 0.
- R2: Source bytes pair up as (2p, 2p+1). Byte 2p supplies bits [7:4] of each output byte and byte 2p+1 supplies bits [3:0].
- R3: Every output byte is one of 0x00, 0x0F, 0xF0 or 0xFF. A nibble is 0xF when its source bit is 1 and 0x0 when it is 0.
- R4: In full width (`narrow_mode`=0), output byte k comes from row k/4 and pair k%4. Row r uses bit r of the source bytes. Exactly 32 bytes are emitted per tile.
- R5: After the last byte of a tile is taken, `m_valid` is 0 and `s_ready` is 1 in the next cycle.
- R6: In narrow width (`narrow_mode`=1), output byte k comes from row k/3 and pair k%3. Exactly 24 bytes are emitted per tile. Source bytes 6 and 7 are accepted but have no effect on the output.
- R7: `narrow_mode` is sampled only when the first source byte of a tile is accepted. Changes at any other time have no effect on that tile.
- R8: `m_valid` stays 0 while a tile is being filled. It rises only in the cycle after the eighth source byte is accepted, and it stays 1 until the tile is drained.
- R9: While `m_valid` is 1 and `m_ready` is 0, `m_data` and `m_valid` hold their values in the next cycle.
- R10: `s_ready` is 1 throughout filling and 0 from the eighth accepted byte until the last output byte is taken. No source byte is accepted while output is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| narrow_mode | input | 1 | 1 selects the 24-byte narrow layout, sampled with the first byte |
| s_valid | input | 1 | Source byte valid |
| s_ready | output | 1 | Block can accept a source byte |
| s_data | input | 8 | Source pixel column, bit 0 is the top row |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream takes the output byte |
| m_data | output | 8 | Two packed 4-bit pixels |

## Verification
The bench builds the block with its default parameters: 8 rows per tile, 8 source bytes and 4-bit nibbles. With these values both output widths are reachable, as is every row/pair position and the discarding of the two spare source bytes. Random tiles run with random input gaps, random output stalls and a mode input that toggles after the first byte. Directed all-dark, all-lit, single-column and walking-bit tiles pin down the nibble order and the row order.

// File: rtl/gray_tile_pkg.sv
// Shared definitions for the monochrome-to-grayscale tile converter.
// Assumes a two-level source: a pixel is either fully off or fully on.
package gray_tile_pkg;

    localparam int GRAY_NIB_W = 4;

    typedef logic [GRAY_NIB_W-1:0] gray_nib_t;

    // Expand one monochrome pixel to a full-scale or zero intensity nibble.
    function automatic gray_nib_t bit_to_nib(input logic pix);
        return pix ? '1 : '0;
    endfunction

endpackage

// File: rtl/tile_collect.sv
// Input side: accepts SRC_BYTES pixel columns over a valid/ready stream
// and holds them until the emitter reports the tile drained.
// Assumes drained_i pulses only while loaded_o is high.
module tile_collect #(
    parameter int SRC_W     = 8,
    parameter int SRC_BYTES = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 s_valid,
    input  logic [SRC_W-1:0]                     s_data,
    input  logic                                 narrow_i,
    input  logic                                 drained_i,
    output logic                                 s_ready,
    output logic                                 loaded_o,
    output logic                                 narrow_o,
    output logic [SRC_BYTES-1:0][SRC_W-1:0]      tile_o
);
    localparam int CNT_W = $clog2(SRC_BYTES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SRC_BYTES - 1);

    logic [CNT_W-1:0] fill_cnt;
    logic             loaded_q;
    logic             narrow_q;
    logic             accept;

    assign s_ready  = !loaded_q;
    assign accept   = s_valid && s_ready;
    assign loaded_o = loaded_q;
    assign narrow_o = narrow_q;

    // Fill counter, tile-loaded flag and per-tile mode capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_cnt <= '0;
            loaded_q <= 1'b0;
            narrow_q <= 1'b0;
        end else if (accept) begin
            if (fill_cnt == '0) begin
                narrow_q <= narrow_i;
            end
            if (fill_cnt == CNT_LAST) begin
                fill_cnt <= '0;
                loaded_q <= 1'b1;
            end else begin
                fill_cnt <= fill_cnt + 1'b1;
            end
        end else if (drained_i) begin
            loaded_q <= 1'b0;
        end
    end

    // One storage lane per source column, written at its fill position.
    for (genvar g = 0; g < SRC_BYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (accept && fill_cnt == CNT_W'(g)) begin
                tile_o[g] <= s_data;
            end
        end
    end

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded_q && !drained_i) |=> $stable(narrow_q)); // R7

    AST_FILL_IDLE_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        loaded_q |-> (fill_cnt == '0)); // R10

endmodule

// File: rtl/tile_emit.sv
// Output side: walks the held tile row by row and pair by pair, packing
// two expanded pixels per byte. Narrow mode stops each row one pair early.
// Assumes tile_i and narrow_i are stable while loaded_i is high.
module tile_emit
    import gray_tile_pkg::*;
#(
    parameter int SRC_W     = 8,
    parameter int SRC_BYTES = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 loaded_i,
    input  logic                                 narrow_i,
    input  logic [SRC_BYTES-1:0][SRC_W-1:0]      tile_i,
    input  logic                                 m_ready,
    output logic                                 m_valid,
    output logic [2*GRAY_NIB_W-1:0]              m_data,
    output logic                                 drained_o
);
    localparam int PAIRS  = SRC_BYTES / 2;
    localparam int PAIR_W = $clog2(PAIRS);
    localparam int ROW_W  = $clog2(SRC_W);
    localparam int OUT_W  = 2 * GRAY_NIB_W;
    localparam logic [PAIR_W-1:0] LAST_FULL   = PAIR_W'(PAIRS - 1);
    localparam logic [PAIR_W-1:0] LAST_NARROW = PAIR_W'(PAIRS - 2);
    localparam logic [ROW_W-1:0]  ROW_LAST    = ROW_W'(SRC_W - 1);

    logic [PAIR_W-1:0]            pair_q;
    logic [ROW_W-1:0]             row_q;
    logic [PAIR_W-1:0]            pair_last;
    logic [PAIRS-1:0][OUT_W-1:0]  pair_word;
    logic                         fire;

    assign pair_last = narrow_i ? LAST_NARROW : LAST_FULL;
    assign m_valid   = loaded_i;
    assign fire      = m_valid && m_ready;
    assign drained_o = fire && (pair_q == pair_last) && (row_q == ROW_LAST);

    // Pack the current row of each column pair: even column high, odd low.
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign pair_word[p] = {bit_to_nib(tile_i[2*p][row_q]),
                               bit_to_nib(tile_i[2*p+1][row_q])};
    end

    assign m_data = pair_word[pair_q];

    // Advance pair within a row, then row, on each accepted output byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_q <= '0;
            row_q  <= '0;
        end else if (fire) begin
            if (pair_q == pair_last) begin
                pair_q <= '0;
                row_q  <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
            end else begin
                pair_q <= pair_q + 1'b1;
            end
        end
    end

    AST_PAIR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (pair_q <= pair_last)); // R6

    AST_BYTE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (m_data inside {8'h00, 8'h0F, 8'hF0, 8'hFF})); // R3

    AST_IDLE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        !loaded_i |-> (pair_q == '0 && row_q == '0)); // R5

endmodule

// File: rtl/gray_tile_xpose.sv
// Top: converts one column-major 1-bit tile into a row-major, nibble-packed
// 4-bit grayscale block. One tile in flight; fill and drain do not overlap.
module gray_tile_xpose #(
    parameter int SRC_W     = 8,
    parameter int SRC_BYTES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             narrow_mode,
    input  logic             s_valid,
    output logic             s_ready,
    input  logic [SRC_W-1:0] s_data,
    output logic             m_valid,
    input  logic             m_ready,
    output logic [7:0]       m_data
);
    logic                            loaded;
    logic                            narrow_q;
    logic                            drained;
    logic [SRC_BYTES-1:0][SRC_W-1:0] tile;

    tile_collect #(.SRC_W(SRC_W), .SRC_BYTES(SRC_BYTES)) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_valid   (s_valid),
        .s_data    (s_data),
        .narrow_i  (narrow_mode),
        .drained_i (drained),
        .s_ready   (s_ready),
        .loaded_o  (loaded),
        .narrow_o  (narrow_q),
        .tile_o    (tile)
    );

    tile_emit #(.SRC_W(SRC_W), .SRC_BYTES(SRC_BYTES)) u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .loaded_i  (loaded),
        .narrow_i  (narrow_q),
        .tile_i    (tile),
        .m_ready   (m_ready),
        .m_valid   (m_valid),
        .m_data    (m_data),
        .drained_o (drained)
    );

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data))); // R9

    AST_FILL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_valid) |-> $past(s_valid && s_ready)); // R8

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |-> !m_valid); // R10

endmodule

// File: tb/gray_tile_xpose_bench.sv
module gray_tile_xpose_bench;
    logic       clk = 1'b0;
    logic       rst_n, narrow_mode, s_valid, m_ready;
    logic [7:0] s_data;
    logic       s_ready, m_valid;
    logic [7:0] m_data;
    int         checks = 0;
    int         fails  = 0;
    logic [7:0] cur [8];

    always #5 clk = ~clk;

    gray_tile_xpose u_gray_tile_xpose (
        .clk(clk), .rst_n(rst_n), .narrow_mode(narrow_mode),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
    );

    // Expected byte k from the requirement formulas (R2, R4, R6).
    function automatic logic [7:0] exp_byte(input logic narrow, input int k);
        int w   = narrow ? 3 : 4;
        int row = k / w;
        int p   = k % w;
        logic [7:0] v;
        v[7:4] = cur[2*p][row]   ? 4'hF : 4'h0;
        v[3:0] = cur[2*p+1][row] ? 4'hF : 4'h0;
        return v;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Feed the 8 columns; mode is only meaningful with column 0 (R7).
    task automatic send_tile(input bit narrow);
        for (int k = 0; k < 8; k++) begin
            int gaps = $urandom_range(0, 2);
            repeat (gaps) begin
                @(negedge clk);
                s_valid = 1'b0;
                #1;
                check(m_valid === 1'b0, "R8 fill", {7'd0, m_valid}, 8'd0);
            end
            @(negedge clk);
            s_valid     = 1'b1;
            s_data      = cur[k];
            narrow_mode = (k == 0) ? narrow : 1'($urandom_range(0, 1));
            #1;
            check(s_ready === 1'b1, "R10 fill ready", {7'd0, s_ready}, 8'd1);
            check(m_valid === 1'b0, "R8 fill", {7'd0, m_valid}, 8'd0);
            @(posedge clk);
        end
        // Offer a stray byte during drain; it must be refused (R10).
        @(negedge clk);
        s_valid     = 1'b1;
        s_data      = 8'hA5;
        narrow_mode = ~narrow;
    endtask

    task automatic recv_tile(input bit narrow, input bit stall);
        int         n = narrow ? 24 : 32;
        int         idx = 0;
        bit         prev_stall = 1'b0;
        logic [7:0] prev_data = 8'h00;
        string      req = narrow ? "R2 R6 R7" : "R2 R4 R7";
        while (idx < n) begin
            @(negedge clk);
            m_ready = stall ? ($urandom_range(0, 3) != 0) : 1'b1;
            #1;
            check(m_valid === 1'b1, "R8 drain valid", {7'd0, m_valid}, 8'd1);
            check(s_ready === 1'b0, "R10 drain ready", {7'd0, s_ready}, 8'd0);
            if (prev_stall)
                check(m_data === prev_data, "R9 stall hold", m_data, prev_data);
            check(m_data === exp_byte(narrow, idx), req, m_data, exp_byte(narrow, idx));
            check(m_data inside {8'h00, 8'h0F, 8'hF0, 8'hFF}, "R3 levels", m_data, 8'h00);
            prev_stall = !m_ready;
            prev_data  = m_data;
            if (m_ready) begin
                idx++;
                if (idx == n) s_valid = 1'b0;
            end
        end
        @(negedge clk);
        m_ready = 1'b0;
        #1;
        check(m_valid === 1'b0, narrow ? "R6 count" : "R4 count", {7'd0, m_valid}, 8'd0);
        check(s_ready === 1'b1, "R5 reopen", {7'd0, s_ready}, 8'd1);
    endtask

    task automatic run_tile(input bit narrow, input bit stall);
        send_tile(narrow);
        recv_tile(narrow, stall);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; narrow_mode = 1'b0; s_valid = 1'b0; m_ready = 1'b0; s_data = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(s_ready === 1'b1, "R1 ready", {7'd0, s_ready}, 8'd1);
        check(m_valid === 1'b0, "R1 valid", {7'd0, m_valid}, 8'd0);

        // Directed: all dark, all lit, left column only, walking bit.
        for (int k = 0; k < 8; k++) cur[k] = 8'h00;
        run_tile(1'b0, 1'b0);
        for (int k = 0; k < 8; k++) cur[k] = 8'hFF;
        run_tile(1'b0, 1'b1);
        run_tile(1'b1, 1'b0);  // R6: lit bytes 6 and 7 must not appear
        for (int k = 0; k < 8; k++) cur[k] = (k == 0) ? 8'hFF : 8'h00;
        run_tile(1'b0, 1'b0);  // R2: high nibble from the even column
        for (int k = 0; k < 8; k++) cur[k] = 8'(1 << k);
        run_tile(1'b0, 1'b1);  // R4: row order from bit position
        run_tile(1'b1, 1'b1);

        // Random tiles, random mode, random stalls.
        for (int t = 0; t < 40; t++) begin
            for (int k = 0; k < 8; k++) cur[k] = 8'($urandom);
            run_tile(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule